// File: doc/BRIEF.md
# Vector branch condition reduction sequencer

This block decides a vector conditional branch by walking the elements of a vector one at a time. A start pulse captures the instruction's branch options, the predicate mask, the vector length, the count register and the current instruction address. Then one element is handled per clock. For each element the block reads a 4-bit condition field from an external condition store, picks one bit of it, and tests that bit against the branch options. The per-element results are combined as a conjunction (every test must pass) or as a disjunction (any single pass is enough). The walk ends as soon as the outcome is known.

Along the way the count register may be decremented under several rules chosen by the mode bits. The vector length may also be cut at the decision point. When the walk ends, a one-cycle done pulse presents the results: the taken decision, the next instruction address, the link value and its write enable, the state-link write enable, the final count and the resulting vector length. The block does not decode the instruction, does not hold the condition store and does not speculate.

Top module: `vbr_seq`

## Requirements
- R1: The cycle after an accepted start, the block begins reading one element per cycle through `fld_idx` and `fld_rd`. For a vector operand the field read for element i is `(bi[8:2] + i) mod 128`. For a scalar operand it is always `bi[8:2]`. The tested bit is `fld_data[k]` with `k = bi[1:0]`. A read happens only for an element whose predicate bit is set.
- R2: An element passes only when two checks hold. The condition check holds when `bo[4]` is 1 or the tested bit equals `bo[3]`. The count check holds when `bo[2]` is 1 or (count nonzero) XOR `bo[1]` is 1. The count used is the value before this element's own decrement. `bo[0]` is unused.
- R3: With `all_mode`=1 the branch is taken only if every tested element passes. The walk stops after the first failing element, and no later element is read.
- R4: With `all_mode`=0 the branch is taken if any tested element passes. The walk stops after the first passing element.
- R5: A masked-out element with `sz`=0 is skipped: it is not read, not tested and does not affect the outcome. With `sz`=1 it is tested without a read, and `snz` stands in for the tested bit.
- R6: Decrements happen only when `bo[2]`=0. For (`ctr_test`,`ctr_inv`) = 0/0 the count drops on every tested element. For 1/0 it drops when the condition check passes. For 1/1 it drops when the condition check fails. For 0/1 it drops only on skipped masked-out elements, never on tested ones.
- R7: With `mode64`=0 the count's zero test uses only its low 32 bits. With `mode64`=1 it uses all 64 bits.
- R8: With `vl_set`=1, an element whose pass result equals `vl_sense` ends the walk. When `vl_incl`=1, `vl_out` becomes that element's index plus 1, and the count rule for that element still applies. When `vl_incl`=0, `vl_out` becomes one past the last tested element before it (0 if none), and that element does not decrement the count. When no truncation occurs, `vl_out` equals the vector length.
- R9: With vector length 0 no element is read. The branch is taken when `all_mode`=1 and not taken when `all_mode`=0.
- R10: A scalar operand (`vec_op`=0) ends the walk after the first tested element.
- R11: `nia` is `cia`+8 when not taken. When taken it is the sign-extended `bd` shifted left by 2, used as-is if `aa`=1 or added to `cia` otherwise.
- R12: At done, `lr_we` = `lk` XOR (taken AND `lr_upd`) and `svlr_we` = `sl` XOR (taken AND `sl_upd`). `lr_val` is `cia`+8. Both enables are 0 outside the done cycle.
- R13: After reset `busy`, `done` and `fld_rd` are 0. `done` is a single-cycle pulse. Results hold until the next accepted start, and a start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches an evaluation when idle |
| bo | input | 5 | Branch options: ignore-condition, sense, ignore-count, count sense, unused |
| bi | input | 9 | Field number [8:2] and bit select [1:0] |
| vec_op | input | 1 | 1 = field number advances per element |
| all_mode | input | 1 | 1 = conjunction, 0 = disjunction |
| sz | input | 1 | Masked elements are tested using `snz` |
| snz | input | 1 | Substitute bit for masked elements |
| ctr_test | input | 1 | Count decrement follows the condition result |
| ctr_inv | input | 1 | Inverts the count decrement choice |
| vl_set | input | 1 | Enables vector length truncation |
| vl_sense | input | 1 | Pass value that triggers truncation |
| vl_incl | input | 1 | Truncated length includes the current element |
| lk | input | 1 | Link update request |
| lr_upd | input | 1 | Invert link request when taken |
| sl | input | 1 | State-link update request |
| sl_upd | input | 1 | Invert state-link request when taken |
| aa | input | 1 | Absolute target |
| mode64 | input | 1 | 64-bit count zero test |
| pred_mask | input | 64 | Predicate bit per element |
| vl | input | 7 | Vector length, 0..64 |
| ctr_in | input | 64 | Count register value |
| cia | input | 64 | Current instruction address |
| bd | input | 14 | Branch displacement in words |
| fld_idx | output | 7 | Condition field number being read |
| fld_rd | output | 1 | Read strobe for `fld_idx` |
| fld_data | input | 4 | Condition field returned in the same cycle |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result pulse |
| taken | output | 1 | Branch decision |
| nia | output | 64 | Next instruction address |
| lr_we | output | 1 | Link write enable |
| lr_val | output | 64 | Link value |
| svlr_we | output | 1 | State-link write enable |
| ctr_out | output | 64 | Count after the walk |
| vl_out | output | 7 | Vector length after the walk |

## Verification
The delicate overlap is the element where truncation fires in the same cycle as a count decrement would. With `vl_incl`=0 the truncation must cancel that element's decrement; with `vl_incl`=1 both happen together. The bench provokes this with the 0b110010 mask and a failing element 4, once with each inclusion setting and once with substitution enabled. In every case it judges `vl_out` together with `ctr_out` against a loop model. Each read is also compared with the model's expected field sequence, which catches an exit taken one element too late.

// File: rtl/vbr_pkg.sv
package vbr_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } vbr_state_e;

    // captured options of one branch evaluation
    typedef struct packed {
        logic [4:0] bo;
        logic       vec;
        logic       all_m;
        logic       sz;
        logic       snz;
        logic       ctr_test;
        logic       ctr_inv;
        logic       vl_set;
        logic       vl_sense;
        logic       vl_incl;
        logic       lk;
        logic       lr_upd;
        logic       sl;
        logic       sl_upd;
        logic       aa;
        logic       mode64;
    } vbr_mode_t;

    // verdict on the element currently addressed
    typedef struct packed {
        logic skip;    // masked out and not substituted
        logic pass;    // condition and count checks both hold
        logic dec;     // count register decrements this cycle
        logic vl_hit;  // truncation fires here
        logic stop;    // walk ends after this element
    } vbr_elem_t;

    function automatic logic pick_bit(input logic [3:0] fld, input logic [1:0] k);
        return fld[k];
    endfunction

    function automatic logic cond_check(input logic [4:0] bo, input logic tb);
        return bo[4] | ~(tb ^ bo[3]);
    endfunction

    function automatic logic count_check(input logic [4:0] bo, input logic nz);
        return bo[2] | (nz ^ bo[1]);
    endfunction

endpackage

// File: rtl/vbr_elem.sv
module vbr_elem
    import vbr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  vbr_mode_t        md,
    input  logic             pred,
    input  logic             fbit,
    input  logic [XLEN-1:0]  ctr,
    output vbr_elem_t        er
);
    localparam int LOW = (XLEN > 32) ? 32 : XLEN;

    logic tb, cond, nz, cok, pass, skip, hit, dec_t;

    always_comb begin
        skip  = ~pred & ~md.sz;
        tb    = pred ? fbit : md.snz;
        cond  = cond_check(md.bo, tb);
        nz    = md.mode64 ? (|ctr) : (|ctr[LOW-1:0]);
        cok   = count_check(md.bo, nz);
        pass  = cond & cok;
        hit   = ~skip & md.vl_set & (pass == md.vl_sense);
        // decrement rule for a tested element
        if (md.ctr_test) dec_t = cond ^ md.ctr_inv;
        else             dec_t = ~md.ctr_inv;
        er.skip   = skip;
        er.pass   = pass;
        er.vl_hit = hit;
        if (skip)
            er.dec = ~md.bo[2] & ~md.ctr_test & md.ctr_inv;
        else
            er.dec = ~md.bo[2] & dec_t & ~(hit & ~md.vl_incl);
        er.stop = ~skip & (hit | (md.all_m != pass) | ~md.vec);
    end

endmodule

// File: rtl/vbr_ctrl.sv
module vbr_ctrl
    import vbr_pkg::*;
#(
    parameter int VLMAX = 64,
    parameter int XLEN  = 64,
    parameter int FW    = 7,
    localparam int VLW  = $clog2(VLMAX + 1),
    localparam int IW   = $clog2(VLMAX)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  vbr_mode_t         md_in,
    input  logic [FW+1:0]     bi_in,
    input  logic [VLMAX-1:0]  mask_in,
    input  logic [VLW-1:0]    vl_in,
    input  logic [XLEN-1:0]   ctr_in,
    input  vbr_elem_t         er,
    output vbr_mode_t         md,
    output logic              cur_pred,
    output logic [1:0]        bsel,
    output logic [XLEN-1:0]   ctr_q,
    output logic [FW-1:0]     fld_idx,
    output logic              fld_rd,
    output logic              busy,
    output logic              accept,
    output logic              done,
    output logic              taken,
    output logic [VLW-1:0]    vl_out
);
    vbr_state_e         st_q;
    logic [FW+1:0]      bi_q;
    logic [VLMAX-1:0]   mask_q;
    logic [VLW-1:0]     idx_q, tend_q, vl_q, vlr_q;
    logic               acc_q, done_q, tk_q;
    logic               in_run, at_end, live, acc_nx;
    logic [VLW-1:0]     vl_new;

    always_comb begin
        in_run   = (st_q == ST_RUN);
        at_end   = (idx_q >= vl_q);
        live     = in_run & ~at_end;
        cur_pred = (idx_q < VLW'(VLMAX)) ? mask_q[idx_q[IW-1:0]] : 1'b0;
        acc_nx   = md.all_m ? (acc_q & er.pass) : (acc_q | er.pass);
        vl_new   = md.vl_incl ? (idx_q + VLW'(1)) : tend_q;
        fld_idx  = bi_q[FW+1:2] + (md.vec ? FW'(idx_q) : FW'(0));
        fld_rd   = live & cur_pred;
    end

    assign bsel   = bi_q[1:0];
    assign busy   = in_run;
    assign accept = start & ~in_run;
    assign done   = done_q;
    assign taken  = tk_q;
    assign vl_out = vlr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            md     <= '0;
            bi_q   <= '0;
            mask_q <= '0;
            idx_q  <= '0;
            tend_q <= '0;
            vl_q   <= '0;
            vlr_q  <= '0;
            ctr_q  <= '0;
            acc_q  <= 1'b0;
            done_q <= 1'b0;
            tk_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        md     <= md_in;
                        bi_q   <= bi_in;
                        mask_q <= mask_in;
                        vl_q   <= vl_in;
                        vlr_q  <= vl_in;
                        ctr_q  <= ctr_in;
                        idx_q  <= '0;
                        tend_q <= '0;
                        acc_q  <= md_in.all_m;
                        st_q   <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (at_end) begin
                        done_q <= 1'b1;
                        tk_q   <= acc_q;
                        st_q   <= ST_IDLE;
                    end else begin
                        if (er.dec) ctr_q <= ctr_q - XLEN'(1);
                        if (!er.skip) begin
                            acc_q  <= acc_nx;
                            tend_q <= idx_q + VLW'(1);
                        end
                        if (er.vl_hit) vlr_q <= vl_new;
                        if (er.stop) begin
                            done_q <= 1'b1;
                            tk_q   <= acc_nx;
                            st_q   <= ST_IDLE;
                        end else begin
                            idx_q <= idx_q + VLW'(1);
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R13

    AST_CTR_STEP: assert property (@(posedge clk) disable iff (rst)
        in_run |=> (ctr_q == $past(ctr_q) || ctr_q == $past(ctr_q) - XLEN'(1))); // R6

    AST_VL_NO_GROW: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (vlr_q <= vl_q)); // R8

    AST_VL_ZERO: assert property (@(posedge clk) disable iff (rst)
        (done_q && vl_q == '0) |-> (tk_q == md.all_m)); // R9

    AST_SCALAR_ONCE: assert property (@(posedge clk) disable iff (rst)
        (fld_rd && !md.vec) |=> !fld_rd); // R10

    AST_ALL_EXIT: assert property (@(posedge clk) disable iff (rst)
        (fld_rd && md.all_m && !er.pass) |=> !busy); // R3

endmodule

// File: rtl/vbr_target.sv
module vbr_target
    import vbr_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int BDW  = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic [XLEN-1:0]  cia,
    input  logic [BDW-1:0]   bd,
    input  vbr_mode_t        md,
    input  logic             done,
    input  logic             taken,
    output logic [XLEN-1:0]  nia,
    output logic [XLEN-1:0]  lr_val,
    output logic             lr_we,
    output logic             svlr_we
);
    localparam int EXTW = XLEN - BDW - 2;

    logic [XLEN-1:0] cia_q, off, seq_pc;
    logic [BDW-1:0]  bd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cia_q <= '0;
            bd_q  <= '0;
        end else if (accept) begin
            cia_q <= cia;
            bd_q  <= bd;
        end
    end

    always_comb begin
        off     = {{EXTW{bd_q[BDW-1]}}, bd_q, 2'b00};
        seq_pc  = cia_q + XLEN'(8);
        nia     = taken ? (md.aa ? off : cia_q + off) : seq_pc;
        lr_val  = seq_pc;
        lr_we   = done & (md.lk ^ (taken & md.lr_upd));
        svlr_we = done & (md.sl ^ (taken & md.sl_upd));
    end

    AST_LINK_GATE: assert property (@(posedge clk) disable iff (rst)
        (lr_we && !md.lk) |-> (taken && md.lr_upd)); // R12

    AST_SVLINK_GATE: assert property (@(posedge clk) disable iff (rst)
        (svlr_we && !md.sl) |-> (taken && md.sl_upd)); // R12

endmodule

// File: rtl/vbr_seq.sv
module vbr_seq
    import vbr_pkg::*;
#(
    parameter int VLMAX = 64,
    parameter int XLEN  = 64,
    parameter int BDW   = 14,
    parameter int FW    = 7,
    localparam int VLW  = $clog2(VLMAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [4:0]        bo,
    input  logic [FW+1:0]     bi,
    input  logic              vec_op,
    input  logic              all_mode,
    input  logic              sz,
    input  logic              snz,
    input  logic              ctr_test,
    input  logic              ctr_inv,
    input  logic              vl_set,
    input  logic              vl_sense,
    input  logic              vl_incl,
    input  logic              lk,
    input  logic              lr_upd,
    input  logic              sl,
    input  logic              sl_upd,
    input  logic              aa,
    input  logic              mode64,
    input  logic [VLMAX-1:0]  pred_mask,
    input  logic [VLW-1:0]    vl,
    input  logic [XLEN-1:0]   ctr_in,
    input  logic [XLEN-1:0]   cia,
    input  logic [BDW-1:0]    bd,
    output logic [FW-1:0]     fld_idx,
    output logic              fld_rd,
    input  logic [3:0]        fld_data,
    output logic              busy,
    output logic              done,
    output logic              taken,
    output logic [XLEN-1:0]   nia,
    output logic              lr_we,
    output logic [XLEN-1:0]   lr_val,
    output logic              svlr_we,
    output logic [XLEN-1:0]   ctr_out,
    output logic [VLW-1:0]    vl_out
);
    vbr_mode_t md_in, md;
    vbr_elem_t er;
    logic      cur_pred, fbit, accept;
    logic [1:0] bsel;

    always_comb begin
        md_in.bo       = bo;
        md_in.vec      = vec_op;
        md_in.all_m    = all_mode;
        md_in.sz       = sz;
        md_in.snz      = snz;
        md_in.ctr_test = ctr_test;
        md_in.ctr_inv  = ctr_inv;
        md_in.vl_set   = vl_set;
        md_in.vl_sense = vl_sense;
        md_in.vl_incl  = vl_incl;
        md_in.lk       = lk;
        md_in.lr_upd   = lr_upd;
        md_in.sl       = sl;
        md_in.sl_upd   = sl_upd;
        md_in.aa       = aa;
        md_in.mode64   = mode64;
    end

    assign fbit = pick_bit(fld_data, bsel);

    vbr_ctrl #(.VLMAX(VLMAX), .XLEN(XLEN), .FW(FW)) u_ctrl (
        .clk(clk), .rst(rst), .start(start),
        .md_in(md_in), .bi_in(bi), .mask_in(pred_mask), .vl_in(vl), .ctr_in(ctr_in),
        .er(er), .md(md), .cur_pred(cur_pred), .bsel(bsel), .ctr_q(ctr_out),
        .fld_idx(fld_idx), .fld_rd(fld_rd), .busy(busy), .accept(accept),
        .done(done), .taken(taken), .vl_out(vl_out)
    );

    vbr_elem #(.XLEN(XLEN)) u_elem (
        .md(md), .pred(cur_pred), .fbit(fbit), .ctr(ctr_out), .er(er)
    );

    vbr_target #(.XLEN(XLEN), .BDW(BDW)) u_target (
        .clk(clk), .rst(rst), .accept(accept), .cia(cia), .bd(bd), .md(md),
        .done(done), .taken(taken), .nia(nia), .lr_val(lr_val),
        .lr_we(lr_we), .svlr_we(svlr_we)
    );

endmodule

// File: tb/vbr_seq_test.sv
module vbr_seq_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic start = 0;
    logic [4:0] bo = 0;
    logic [8:0] bi = 0;
    logic vec_op = 0, all_mode = 0, sz = 0, snz = 0, ctr_test = 0, ctr_inv = 0;
    logic vl_set = 0, vl_sense = 0, vl_incl = 0, lk = 0, lr_upd = 0, sl = 0, sl_upd = 0;
    logic aa = 0, mode64 = 1;
    logic [63:0] pred_mask = 0;
    logic [6:0]  vl = 0;
    logic [63:0] ctr_in = 0, cia = 0;
    logic [13:0] bd = 0;
    logic [6:0]  fld_idx;
    logic        fld_rd, busy, done, taken, lr_we, svlr_we;
    logic [3:0]  fld_data;
    logic [63:0] nia, lr_val, ctr_out;
    logic [6:0]  vl_out;

    logic [3:0] crf [128];
    assign fld_data = crf[fld_idx];

    vbr_seq uut (
        .clk(clk), .rst(rst), .start(start), .bo(bo), .bi(bi), .vec_op(vec_op),
        .all_mode(all_mode), .sz(sz), .snz(snz), .ctr_test(ctr_test), .ctr_inv(ctr_inv),
        .vl_set(vl_set), .vl_sense(vl_sense), .vl_incl(vl_incl), .lk(lk), .lr_upd(lr_upd),
        .sl(sl), .sl_upd(sl_upd), .aa(aa), .mode64(mode64), .pred_mask(pred_mask),
        .vl(vl), .ctr_in(ctr_in), .cia(cia), .bd(bd), .fld_idx(fld_idx), .fld_rd(fld_rd),
        .fld_data(fld_data), .busy(busy), .done(done), .taken(taken), .nia(nia),
        .lr_we(lr_we), .lr_val(lr_val), .svlr_we(svlr_we), .ctr_out(ctr_out), .vl_out(vl_out)
    );

    int n_chk = 0;
    int n_err = 0;
    int exp_rd [$];
    logic e_taken, e_lrwe, e_svwe;
    logic [63:0] e_ctr, e_nia;
    int e_vl;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic fill(input logic [3:0] v);
        for (int i = 0; i < 128; i++) crf[i] = v;
    endtask

    task automatic defaults();
        bo = 5'b01100; bi = 0; vec_op = 1; all_mode = 0; sz = 0; snz = 0;
        ctr_test = 0; ctr_inv = 0; vl_set = 0; vl_sense = 0; vl_incl = 0;
        lk = 0; lr_upd = 0; sl = 0; sl_upd = 0; aa = 0; mode64 = 1;
        pred_mask = '1; vl = 4; ctr_in = 64'd100; cia = 64'h1000; bd = 14'd16;
    endtask

    // behavioural reference: a plain loop over the elements
    task automatic model();
        logic [63:0] c;
        logic acc, p, tb, cond, nz, ok, hit, dec;
        logic [63:0] off;
        int tend, f;
        c = ctr_in; acc = all_mode; tend = 0; e_vl = vl;
        exp_rd.delete();
        for (int i = 0; i < vl; i++) begin
            p = pred_mask[i];
            if (!p && !sz) begin
                if (!bo[2] && !ctr_test && ctr_inv) c = c - 1;
                continue;
            end
            f = (int'(bi[8:2]) + (vec_op ? i : 0)) % 128;
            if (p) begin
                exp_rd.push_back(f);
                tb = crf[f][bi[1:0]];
            end else tb = snz;
            cond = bo[4] | (tb == bo[3]);
            nz = mode64 ? (c != 0) : (c[31:0] != 0);
            ok = cond & (bo[2] | (nz ^ bo[1]));
            hit = vl_set && (ok == vl_sense);
            if (ctr_test) dec = (cond != ctr_inv);
            else dec = !ctr_inv;
            if (hit && !vl_incl) dec = 0;
            if (!bo[2] && dec) c = c - 1;
            acc = all_mode ? (acc & ok) : (acc | ok);
            if (hit) begin
                e_vl = vl_incl ? i + 1 : tend;
                break;
            end
            tend = i + 1;
            if (all_mode != ok) break;
            if (!vec_op) break;
        end
        e_taken = acc;
        e_ctr = c;
        off = 64'($signed(bd)) <<< 2;
        e_nia = acc ? (aa ? off : cia + off) : cia + 64'd8;
        e_lrwe = lk ^ (acc & lr_upd);
        e_svwe = sl ^ (acc & sl_upd);
    endtask

    task automatic run(input string tag);
        int cyc;
        bit bad;
        model();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        cyc = 0; bad = 0;
        while (!done && cyc < 500) begin
            if (fld_rd) begin
                if (exp_rd.size() == 0) bad = 1;
                else if (exp_rd[0] != int'(fld_idx)) bad = 1;
                else void'(exp_rd.pop_front());
            end
            @(negedge clk); cyc++;
        end
        if (cyc >= 500) chk(tag, "watchdog", 1, 0);
        chk(tag, "read sequence R1", {63'd0, bad}, 64'(exp_rd.size() != 0));
        chk(tag, "taken", taken, e_taken);
        chk(tag, "nia R11", nia, e_nia);
        chk(tag, "lr_we R12", lr_we, e_lrwe);
        chk(tag, "svlr_we R12", svlr_we, e_svwe);
        chk(tag, "lr_val R12", lr_val, cia + 64'd8);
        chk(tag, "ctr_out", ctr_out, e_ctr);
        chk(tag, "vl_out", vl_out, 64'(e_vl));
        @(negedge clk);
        chk(tag, "done pulse R13", done, 0);
        chk(tag, "result hold R13", taken, e_taken);
    endtask

    initial begin
        fill(4'h0);
        defaults();
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R13", "reset busy", busy, 0);
        chk("R13", "reset done", done, 0);
        chk("R13", "reset fld_rd", fld_rd, 0);

        // R4 R1: disjunction, first pass at element 3, bit 2 of field 13
        fill(4'h0); crf[13] = 4'b0100;
        bi = {7'd10, 2'd2}; vl = 6; lk = 1; lr_upd = 1; bd = -14'sd4;
        run("R4");

        // R3 R6: conjunction all pass, wraps past field 127, count drops per element
        defaults(); fill(4'hF);
        all_mode = 1; bi = {7'd126, 2'd0}; bo = 5'b01000; lk = 1; sl_upd = 1; aa = 1;
        run("R3");

        // R3: conjunction, failure at element 2 ends the walk
        defaults(); fill(4'hF); crf[2] = 4'h0;
        all_mode = 1; vl = 6; lr_upd = 1;
        run("R3");

        // R8 R5: truncation point ignores skipped elements
        defaults(); fill(4'hF); crf[4] = 4'h0;
        all_mode = 1; vl = 6; pred_mask = 64'b110010; bo = 5'b01000; ctr_in = 10;
        vl_set = 1; vl_sense = 0;
        run("R8");
        sz = 1; snz = 1;
        run("R8");
        sz = 0; snz = 0; vl_incl = 1;
        run("R8");

        // R6: decrement only on skipped masked elements
        defaults(); fill(4'h0);
        vl = 6; pred_mask = 64'b110010; bo = 5'b01000; ctr_in = 10; ctr_inv = 1;
        run("R6");
        // R6: decrement follows pass, then follows failure
        defaults(); fill(4'hF); crf[1] = 4'h0;
        all_mode = 0; vl = 5; bo = 5'b01000; ctr_test = 1; crf[0] = 4'h0;
        run("R6");
        ctr_inv = 1;
        run("R6");
        all_mode = 1; fill(4'hF); ctr_inv = 0;
        run("R6");

        // R5: substituted zero fails the conjunction with no read
        defaults(); fill(4'hF);
        all_mode = 1; sz = 1; snz = 0; pred_mask = 64'b1011; vl = 4;
        run("R5");

        // R9: empty vector
        defaults(); vl = 0; all_mode = 1;
        run("R9");
        all_mode = 0;
        run("R9");

        // R10: scalar operand tests one element only
        defaults(); fill(4'h0); crf[5] = 4'h1;
        vec_op = 0; bi = {7'd5, 2'd0}; pred_mask = 64'b000100; vl = 6; all_mode = 1;
        run("R10");
        all_mode = 0; crf[5] = 4'h0;
        run("R10");

        // R7: count zero test width
        defaults();
        bo = 5'b10000; vl = 1; ctr_in = 64'h1_0000_0000; sl = 1;
        run("R7");
        mode64 = 0;
        run("R7");

        // R2: count sense inverted, passes on zero count
        defaults(); fill(4'hF);
        bo = 5'b01010; ctr_in = 0; vl = 3; lk = 1;
        run("R2");

        // R13: start while busy is ignored
        defaults(); fill(4'hF); all_mode = 1; vl = 8; bo = 5'b01000;
        model();
        @(negedge clk); start = 1;
        @(negedge clk); ctr_in = 64'd7;
        @(negedge clk); start = 0;
        repeat (12) @(negedge clk);
        chk("R13", "start ignored while busy", ctr_out, e_ctr);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end
endmodule